// File: doc/BRIEF.md
# Multi-Slot Instruction Skip Controller

This block sits in the issue stage of a simple in-order processor. For every instruction presented at issue it decides whether that instruction runs or is nullified. A nullified instruction still takes its issue cycle, but its register and memory writes are suppressed. The block decodes skip-type instructions and evaluates their condition from a small set of status flags or from one selected bit of a register operand. It keeps a pending-skip window that reaches up to four instructions ahead.

Three skip kinds are supported. A single skip removes the next instruction. A double skip removes the next two, for example an add and its add-with-carry partner. An extended skip carries a mode bit and four per-slot enables. In AND mode it removes any chosen subset of the next four slots. In XOR mode it splits those four slots into a "then" group and an "else" group, which gives a branch-free if/then/else. Code shorter than four instructions is padded with no-ops, because all four slots always take a cycle.

The pending window moves forward only when the pipeline advances. A small two-state machine tracks whether any skip is outstanding. Its states are IDLE, with no slot pending, and SHADOW, with at least one slot pending. Its transitions are ARM (IDLE to SHADOW, when an executed skip sets a slot), DRAIN (SHADOW to IDLE, when the last pending slot shifts out) and HOLD (no change, always during a stall).

Top module: `skip_issue_ctrl`

## Requirements
- R1: Reset empties the pending window, so `nullify` is 0 for the first instruction after reset.
- R2: A skip instruction is recognised by `instr[31:26]` = 6'b111010. Its kind field `instr[25:24]` = 2'b00 selects a single skip. When a single skip issues with a true condition, exactly the next issued instruction is nullified; with a false condition, none is.
- R3: Kind 2'b01 is a double skip. When its condition is true, the next two issued instructions are both nullified and the third is not.
- R4: Kind 2'b10 is an extended skip with field `instr[4:0]`. Bit 4 is the mode (0 = AND, 1 = XOR) and bits 3,2,1,0 are the enables of slots 1,2,3,4. In AND mode an enabled slot is nullified exactly when the condition is true, and a slot with a clear enable always runs.
- R5: In XOR mode an enabled slot is nullified when the condition is true and runs when it is false. A slot with a clear enable gets the opposite outcome. For example, field 5'b10011 with a true condition runs slots 1 and 2 and nullifies slots 3 and 4.
- R6: With `instr[23]` = 0, the raw condition is `flags[instr[20:19]]`, with flags bit 0 = zero, 1 = negative, 2 = carry and 3 = overflow. Setting `instr[21]` forces the raw condition to 1. Setting `instr[22]` inverts the raw condition.
- R7: With `instr[23]` = 1, the raw condition is bit `instr[14:10]` of the 32-bit `operand`; the inversion bit still applies.
- R8: While `advance` is 0 the pending window and `nullify` hold their values, and a skip instruction presented during the stall has no effect until it issues with `advance` = 1.
- R9: A skip instruction that is itself nullified has no effect on the pending window.
- R10: When an executed skip lands inside the window of an earlier skip, a slot is nullified if either skip nullifies it.
- R11: Instructions with another opcode, and skip instructions of kind 2'b11, leave the pending window unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Pipeline-advance enable; the instruction at issue is consumed when high |
| instr | input | 32 | Instruction word at the issue stage |
| flags | input | 4 | Status flags: bit0 zero, bit1 negative, bit2 carry, bit3 overflow |
| operand | input | 32 | Register value used by bit-test skips |
| nullify | output | 1 | High when the instruction at issue must have its writes suppressed |

## Verification
Any corruption of the pending window shows up on `nullify`, but only when the corrupted slot reaches issue. That happens between one and four advancing cycles later, and it is postponed by however long a stall lasts. A wrongly set bit nullifies an instruction that should run. A lost bit lets a skipped instruction through. A window that shifts during a stall moves every later outcome by one slot. An FSM that stays in SHADOW when it should be IDLE, or the reverse, masks or leaks `nullify` on the very next instruction. For this reason, the stimulus mixes long stalls into overlapping XOR and AND windows. A reference model predicts the outcome for every slot.

// File: rtl/skip_pkg.sv
package skip_pkg;

    // Instruction field placement (word is 32 bits)
    localparam int          SK_OP_LSB     = 26;
    localparam int          SK_OP_W       = 6;
    localparam logic [5:0]  SK_OPCODE     = 6'b111010;
    localparam int          SK_KIND_LSB   = 24;
    localparam int          SK_SRC_BIT    = 23;
    localparam int          SK_INV_BIT    = 22;
    localparam int          SK_ALWAYS_BIT = 21;
    localparam int          SK_FSEL_LSB   = 19;
    localparam int          SK_BITN_LSB   = 10;
    localparam int          SK_EXT_LSB    = 0;

    typedef enum logic [1:0] {
        SK_ONE  = 2'b00,
        SK_TWO  = 2'b01,
        SK_EXT  = 2'b10,
        SK_RSVD = 2'b11
    } skip_kind_e;

    typedef enum logic {
        SW_IDLE   = 1'b0,
        SW_SHADOW = 1'b1
    } skip_win_state_e;

endpackage

// File: rtl/skip_decode.sv
module skip_decode
    import skip_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int BIT_W   = 5,
    parameter int FSEL_W  = 2,
    parameter int EXT_W   = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_skip,
    output skip_kind_e         kind,
    output logic               use_bit,
    output logic               invert,
    output logic               force_true,
    output logic [FSEL_W-1:0]  flag_sel,
    output logic [BIT_W-1:0]   bit_num,
    output logic [EXT_W-1:0]   ext_field
);

    logic unused_instr_bits;

    always_comb begin
        is_skip    = (instr[SK_OP_LSB +: SK_OP_W] == SK_OPCODE);
        kind       = skip_kind_e'(instr[SK_KIND_LSB +: 2]);
        use_bit    = instr[SK_SRC_BIT];
        invert     = instr[SK_INV_BIT];
        force_true = instr[SK_ALWAYS_BIT];
        flag_sel   = instr[SK_FSEL_LSB +: FSEL_W];
        bit_num    = instr[SK_BITN_LSB +: BIT_W];
        ext_field  = instr[SK_EXT_LSB +: EXT_W];
    end

    assign unused_instr_bits = ^{instr[18:15], instr[9:5]};

endmodule

// File: rtl/skip_cond_eval.sv
module skip_cond_eval #(
    parameter int DATA_W    = 32,
    parameter int NUM_FLAGS = 4,
    parameter int BIT_W     = $clog2(DATA_W),
    parameter int FSEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 use_bit,
    input  logic                 invert,
    input  logic                 force_true,
    input  logic [FSEL_W-1:0]    flag_sel,
    input  logic [BIT_W-1:0]     bit_num,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [DATA_W-1:0]    operand,
    output logic                 cond
);

    logic flag_raw;
    logic bit_raw;

    always_comb begin
        flag_raw = force_true | flags[flag_sel];
        bit_raw  = operand[bit_num];
        cond     = (use_bit ? bit_raw : flag_raw) ^ invert;
    end

endmodule

// File: rtl/skip_mask_gen.sv
module skip_mask_gen
    import skip_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic              is_skip,
    input  skip_kind_e        kind,
    input  logic              cond,
    input  logic [WINDOW:0]   ext_field,
    output logic [WINDOW-1:0] mask
);

    logic [WINDOW-1:0] ext_mask;
    logic              xor_mode;

    assign xor_mode = ext_field[WINDOW];

    // Slot k+1 enable sits at ext_field[WINDOW-1-k]; mask bit k is slot k+1
    for (genvar k = 0; k < WINDOW; k++) begin : g_slot
        assign ext_mask[k] = xor_mode ? ~(ext_field[WINDOW-1-k] ^ cond)
                                      :  (ext_field[WINDOW-1-k] & cond);
    end

    always_comb begin
        mask = '0;
        if (is_skip) begin
            unique case (kind)
                SK_ONE:  mask[0] = cond;
                SK_TWO:  begin
                    mask[0] = cond;
                    mask[1] = cond;
                end
                SK_EXT:  mask = ext_mask;
                default: mask = '0;
            endcase
        end
    end

endmodule

// File: rtl/skip_window.sv
module skip_window
    import skip_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [WINDOW-1:0] new_mask,
    output logic              nullify,
    output logic [WINDOW-1:0] pending
);

    skip_win_state_e   state_q, state_d;
    logic [WINDOW-1:0] pend_q, pend_d;
    logic [WINDOW-1:0] eff_mask;

    // A skip sitting in a nullified slot contributes nothing
    assign eff_mask = pend_q[0] ? '0 : new_mask;
    assign pend_d   = advance ? ((pend_q >> 1) | eff_mask) : pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:   if (advance && (|eff_mask)) state_d = SW_SHADOW;  // ARM
            SW_SHADOW: if (advance && !(|pend_d))  state_d = SW_IDLE;    // DRAIN
            default:   state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        nullify = (state_q == SW_SHADOW) && pend_q[0];
        pending = pend_q;
    end

endmodule

// File: rtl/skip_issue_ctrl.sv
module skip_issue_ctrl
    import skip_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_FLAGS = 4,
    parameter int WINDOW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic [31:0]          instr,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [DATA_W-1:0]    operand,
    output logic                 nullify
);

    localparam int BIT_W  = $clog2(DATA_W);
    localparam int FSEL_W = $clog2(NUM_FLAGS);
    localparam int EXT_W  = WINDOW + 1;

    logic              is_skip;
    skip_kind_e        kind;
    logic              use_bit, invert, force_true;
    logic [FSEL_W-1:0] flag_sel;
    logic [BIT_W-1:0]  bit_num;
    logic [EXT_W-1:0]  ext_field;
    logic              cond;
    logic [WINDOW-1:0] new_mask;
    logic [WINDOW-1:0] pending_w;

    skip_decode #(
        .INSTR_W(32), .BIT_W(BIT_W), .FSEL_W(FSEL_W), .EXT_W(EXT_W)
    ) u_dec (
        .instr(instr), .is_skip(is_skip), .kind(kind), .use_bit(use_bit),
        .invert(invert), .force_true(force_true), .flag_sel(flag_sel),
        .bit_num(bit_num), .ext_field(ext_field)
    );

    skip_cond_eval #(
        .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS), .BIT_W(BIT_W), .FSEL_W(FSEL_W)
    ) u_cond (
        .use_bit(use_bit), .invert(invert), .force_true(force_true),
        .flag_sel(flag_sel), .bit_num(bit_num), .flags(flags),
        .operand(operand), .cond(cond)
    );

    skip_mask_gen #(.WINDOW(WINDOW)) u_mask (
        .is_skip(is_skip), .kind(kind), .cond(cond),
        .ext_field(ext_field), .mask(new_mask)
    );

    skip_window #(.WINDOW(WINDOW)) u_win (
        .clk(clk), .rst_n(rst_n), .advance(advance), .new_mask(new_mask),
        .nullify(nullify), .pending(pending_w)
    );

endmodule

// File: rtl/skip_ctrl_checker.sv
module skip_ctrl_checker
    import skip_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              nullify,
    input  logic              is_skip,
    input  skip_kind_e        kind,
    input  logic              cond,
    input  logic [WINDOW:0]   ext_field,
    input  logic [WINDOW-1:0] pending
);

    logic tail_empty;
    assign tail_empty = (pending[WINDOW-1:1] == '0);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !nullify);

    assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !nullify && is_skip && kind == SK_ONE && cond) |=> nullify);

    assert_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !nullify && is_skip && kind == SK_TWO && cond) |=> nullify ##1 nullify);

    assert_and_clear_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !nullify && tail_empty && is_skip && kind == SK_EXT
         && !ext_field[WINDOW] && !ext_field[WINDOW-1]) |=> !nullify);

    assert_xor_slot_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !nullify && tail_empty && is_skip && kind == SK_EXT && ext_field[WINDOW])
        |=> (nullify == $past(~(ext_field[WINDOW-1] ^ cond))));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(nullify) && $stable(pending));

    assert_nullified_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && nullify && tail_empty) |=> !nullify);

    assert_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && tail_empty && (!is_skip || kind == SK_RSVD)) |=> !nullify);

endmodule

bind skip_issue_ctrl skip_ctrl_checker #(.WINDOW(WINDOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .advance(advance), .nullify(nullify),
    .is_skip(is_skip), .kind(kind), .cond(cond), .ext_field(ext_field),
    .pending(pending_w)
);

// File: tb/test_skip_issue_ctrl.sv
`timescale 1ns/1ps
module test_skip_issue_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        advance;
    logic [31:0] instr;
    logic [3:0]  flags;
    logic [31:0] operand;
    logic        nullify;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [3:0] pend = 4'b0;
    bit   done = 1'b0;

    localparam logic [31:0] NOP = 32'h0000_0000;

    always #2 clk = ~clk;

    skip_issue_ctrl i_skip_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .advance(advance), .instr(instr),
        .flags(flags), .operand(operand), .nullify(nullify)
    );

    // Encoder: kind, bit-test source, invert, force-true, flag select, bit number, ext field
    function automatic logic [31:0] mk(input logic [1:0] kind, input logic src,
                                       input logic inv, input logic alw,
                                       input logic [1:0] fsel, input logic [4:0] bitn,
                                       input logic [4:0] fld);
        logic [31:0] w;
        w        = '0;
        w[31:26] = 6'b111010;
        w[25:24] = kind;
        w[23]    = src;
        w[22]    = inv;
        w[21]    = alw;
        w[20:19] = fsel;
        w[14:10] = bitn;
        w[4:0]   = fld;
        return w;
    endfunction

    // Expected slot mask of an executed instruction (bit k = slot k+1)
    function automatic logic [3:0] ref_mask(input logic [31:0] w, input logic [31:0] opnd,
                                            input logic [3:0] fl);
        logic       c;
        logic [3:0] m;
        m = 4'b0;
        if (w[31:26] != 6'b111010) return m;
        c = w[23] ? opnd[w[14:10]] : (w[21] ? 1'b1 : fl[w[20:19]]);
        c = c ^ w[22];
        case (w[25:24])
            2'b00: m = {3'b000, c};
            2'b01: m = {2'b00, c, c};
            2'b10: for (int k = 0; k < 4; k++)
                       m[k] = w[4] ? (w[3-k] == c) : (w[3-k] & c);
            default: m = 4'b0;
        endcase
        return m;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: nullify=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic [31:0] opnd, input logic [3:0] fl,
                        input logic adv, input string tag);
        logic [3:0] nxt;
        instr = w; operand = opnd; flags = fl; advance = adv;
        nxt = adv ? ((pend >> 1) | (pend[0] ? 4'b0 : ref_mask(w, opnd, fl))) : pend;
        @(posedge clk);
        @(negedge clk);
        pend = nxt;
        check(nullify, pend[0], tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) step(NOP, 32'h0, 4'h0, 1'b1, tag);
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; advance = 1'b0; instr = NOP; flags = 4'h0; operand = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(nullify, 1'b0, "R1 reset");
        step(NOP, 32'h0, 4'h0, 1'b1, "R1 first instr");

        // R2 single skip: forced true, then zero flag false
        step(mk(2'b00, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R2 single true");
        nops(2, "R2 single after");
        step(mk(2'b00, 0, 0, 0, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R2 single false");
        nops(1, "R2 single false after");

        // R3 double skip on carry
        step(mk(2'b01, 0, 0, 0, 2'd2, 5'd0, 5'd0), 0, 4'h4, 1, "R3 double carry");
        nops(3, "R3 double window");

        // R4 AND mode 0_1010: true -> skip,run,skip,run ; false -> all run
        step(mk(2'b10, 0, 0, 1, 2'd0, 5'd0, 5'b01010), 0, 4'h0, 1, "R4 and true");
        nops(4, "R4 and slots");
        step(mk(2'b10, 0, 1, 1, 2'd0, 5'd0, 5'b01010), 0, 4'h0, 1, "R4 and false");
        nops(4, "R4 and false slots");

        // R5 XOR mode 1_0011: true -> run,run,skip,skip ; false -> opposite
        step(mk(2'b10, 0, 0, 0, 2'd1, 5'd0, 5'b10011), 0, 4'h2, 1, "R5 xor true");
        nops(4, "R5 xor true slots");
        step(mk(2'b10, 0, 0, 0, 2'd1, 5'd0, 5'b10011), 0, 4'h0, 1, "R5 xor false");
        nops(4, "R5 xor false slots");

        // R6 flag select and inversion on overflow
        step(mk(2'b00, 0, 1, 0, 2'd3, 5'd0, 5'd0), 0, 4'h8, 1, "R6 inverted overflow set");
        nops(1, "R6 after");
        step(mk(2'b00, 0, 1, 0, 2'd3, 5'd0, 5'd0), 0, 4'h0, 1, "R6 inverted overflow clear");
        nops(1, "R6 after clear");

        // R7 bit test on bit 17 and bit 31
        step(mk(2'b00, 1, 0, 0, 2'd0, 5'd17, 5'd0), 32'h0002_0000, 4'h0, 1, "R7 bit17 set");
        nops(1, "R7 after");
        step(mk(2'b01, 1, 0, 0, 2'd0, 5'd31, 5'd0), 32'h7FFF_FFFF, 4'h0, 1, "R7 bit31 clear");
        nops(2, "R7 after clear");

        // R8 stall with pending slot and with a skip held at issue
        step(mk(2'b01, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R8 arm");
        for (int i = 0; i < 3; i++) step(NOP, 0, 4'h0, 0, "R8 stall hold");
        nops(3, "R8 drain");
        for (int i = 0; i < 2; i++)
            step(mk(2'b00, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 0, "R8 stalled skip");
        nops(2, "R8 after stall");

        // R9 nullified skip is ignored
        step(mk(2'b00, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R9 first skip");
        step(mk(2'b01, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R9 nullified skip");
        nops(3, "R9 after");

        // R10 overlap: AND on slot 4, slot 1 is a single skip
        step(mk(2'b10, 0, 0, 1, 2'd0, 5'd0, 5'b00001), 0, 4'h0, 1, "R10 outer");
        step(mk(2'b00, 0, 0, 1, 2'd0, 5'd0, 5'd0), 0, 4'h0, 1, "R10 inner");
        nops(4, "R10 union");

        // R11 reserved kind and foreign opcode
        step(mk(2'b11, 0, 0, 1, 2'd0, 5'd0, 5'b11111), 0, 4'hF, 1, "R11 reserved kind");
        w = mk(2'b00, 0, 0, 1, 2'd0, 5'd0, 5'd0); w[26] = 1'b1;
        step(w, 0, 4'hF, 1, "R11 other opcode");
        nops(1, "R11 after");

        // Random mix, R10 covers combined behaviour
        for (int i = 0; i < 3000; i++) begin
            w = ($urandom % 3 != 0) ? mk(2'($urandom), 1'($urandom), 1'($urandom),
                                         1'($urandom), 2'($urandom), 5'($urandom),
                                         5'($urandom))
                                    : $urandom;
            step(w, $urandom, 4'($urandom), ($urandom % 5) != 0, "R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule